// File: doc/BRIEF.md
# Double-Banked Nested-Loop Vector Address Sequencer

This block drives a vector/matrix datapath that works on a circular operand RAM. Software describes one operation as a set of configuration fields: start, step and iteration count for an inner loop and an outer loop, a destination base, a data precision, a first and a second operator code, a broadcast flag and an accumulate flag. The sequencer then walks an outer index J and, inside it, an inner index I. For every (J, I) pair it issues one step carrying the two operand read addresses, the destination address and the operator controls, so that the datapath can form `Res[J] = Res[J] op2 (A[I] op1 B[I])`.

There are two configuration banks. Software fills the bank shown on `next_bank` while the sequencer runs from the other one. The banks trade places only at operation boundaries, so a queued operation follows the current one without a gap. Each step leaves on a valid/ready stream. Once `step_valid` is high it stays high, and every step field stays constant, until a cycle in which `step_ready` is also high. That cycle is the handshake, and the sequencer moves to the next step only after it. Configuration writes, `busy`, `done` and `next_bank` are plain control and status pins.

Top module: `vec_loop_seq`

## Requirements
- R1: After reset, `busy`, `done` and `step_valid` are 0 and `next_bank` is 0.
- R2: A write (`cfg_we`=1) to bank `cfg_bank` stores all fields in that bank and marks it pending, unless that bank is the one in use (the bank not shown on `next_bank`). Such a write is ignored, and so is a write to the pending bank in the very cycle it is taken. While idle, the sequencer starts as soon as the pending bank is valid. With nothing pending it stays idle with `step_valid` at 0.
- R3: Steps come out with the outer count J running 0..NO-1 and, inside each J, the inner count I running 0..NI-1. Let inner = in_start + I*in_step and outer = out_start + J*out_step. Then `step_a_addr` = outer + inner, `step_b_addr` = inner and `step_d_addr` = dst + J.
- R4: With broadcast set, `step_b_addr` equals the outer address for every I of that J.
- R5: An iteration count of 0 acts as 1. The total number of steps is NI*NO.
- R6: `step_op1`, `step_op2` and `step_prec` carry the configured fields. `step_merge` equals the accumulate flag: 1 means combine with Res[J], 0 means overwrite it. `step_first` is 1 exactly when I = 0. `step_last` is 1 only on the final step of the operation.
- R7: Within an operation, two handshakes are at least 2*prec+1 cycles apart, with prec coded 0..3. While `step_ready` stays high the spacing is exactly that.
- R8: While `step_valid` is 1 and `step_ready` is 0, the next cycle keeps `step_valid` at 1 and all step fields unchanged.
- R9: `done` pulses for one cycle, in the cycle after the final step's handshake. If no bank is pending, `busy` falls at that same edge.
- R10: If the other bank is pending when the final handshake occurs, the banks swap at that edge. The next operation's first step then follows after the same 2*prec+1 spacing, with no idle cycle. Banks always alternate.
- R11: Every address is taken modulo 2^AW (AW=6 gives 64 entries), so loops longer than the array wrap around it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_bank | input | 1 | Bank being written |
| cfg_in_start | input | AW | Inner loop start address |
| cfg_in_step | input | AW | Inner loop address step |
| cfg_in_size | input | CW | Inner iteration count (0 acts as 1) |
| cfg_out_start | input | AW | Outer loop start address |
| cfg_out_step | input | AW | Outer loop address step |
| cfg_out_size | input | CW | Outer iteration count (0 acts as 1) |
| cfg_dst | input | AW | Destination base address |
| cfg_prec | input | PW | Precision code, sets step spacing |
| cfg_op1 | input | OPW | Operator combining A and B |
| cfg_op2 | input | OPW | Operator merging into Res[J] |
| cfg_bcast | input | 1 | Hold B address at the outer address |
| cfg_accum | input | 1 | Combine into destination (else overwrite) |
| next_bank | output | 1 | Bank that software may fill next |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| step_valid | output | 1 | Step available |
| step_ready | input | 1 | Downstream accepts the step |
| step_a_addr | output | AW | Operand A read address |
| step_b_addr | output | AW | Operand B read address |
| step_d_addr | output | AW | Destination address |
| step_op1 | output | OPW | First operator code |
| step_op2 | output | OPW | Second operator code |
| step_prec | output | PW | Precision code |
| step_merge | output | 1 | Combine into destination when 1 |
| step_first | output | 1 | First inner step of this J |
| step_last | output | 1 | Final step of the operation |

## Verification
The sweep runs every precision code with every broadcast and accumulate setting, across four loop shapes. Some shapes start near the top of the array, so the addresses wrap, and some have a zero count. Getting an exact address sequence over all of these tells apart an inner/outer ordering error, a missing modulo, a broadcast error and a zero-count error. Alternating between a ready held high and a ready that drops periodically separates exact pacing from back-pressure holding. Separate sequences check three things: queued back-to-back operations, a write to the executing bank, and a write to the bank in use while idle, which must not start anything.

// File: rtl/vls_pkg.sv
package vls_pkg;

  typedef enum logic {
    BANK_PING = 1'b0,
    BANK_PONG = 1'b1
  } bank_e;

  localparam bank_e RESET_ACTIVE = BANK_PONG;

  // Idle cycles enforced after a handshake for a given precision code.
  function automatic int unsigned pace_cycles(input int unsigned prec);
    return 2 * prec;
  endfunction

endpackage

// File: rtl/vls_cfg_store.sv
module vls_cfg_store #(
  parameter int FW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic          wr_bank,
  input  logic [FW-1:0] wr_data,
  input  logic          take,
  output logic          act_bank,
  output logic          pend_valid,
  output logic [FW-1:0] act_data
);
  import vls_pkg::*;

  localparam int NB = 2;

  logic [FW-1:0] bank_q [NB];
  logic [NB-1:0] vld_q;
  logic          act_q;
  logic          act_next;
  logic          wr_ok;

  // bank in use after this edge; writes aimed at it are dropped
  assign act_next = take ? ~act_q : act_q;
  assign wr_ok    = wr && (wr_bank != act_next);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= RESET_ACTIVE;
      vld_q <= '0;
      for (int b = 0; b < NB; b++) bank_q[b] <= '0;
    end else begin
      act_q <= act_next;
      if (take) vld_q[~act_q] <= 1'b0;
      if (wr_ok) begin
        bank_q[wr_bank] <= wr_data;
        vld_q[wr_bank]  <= 1'b1;
      end
    end
  end

  assign act_bank   = act_q;
  assign pend_valid = vld_q[~act_q];
  assign act_data   = bank_q[act_q];

endmodule

// File: rtl/vls_loop_ctr.sv
module vls_loop_ctr #(
  parameter int AW = 6,
  parameter int CW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          adv,
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] step,
  input  logic [CW-1:0] size,
  output logic [AW-1:0] addr,
  output logic [CW-1:0] idx,
  output logic          last
);
  localparam int XW = CW + 1;

  logic [AW-1:0] off_q;
  logic [CW-1:0] idx_q;

  // count 0 behaves as a single iteration
  assign last = (XW'(idx_q) + XW'(1)) >= XW'(size);
  assign addr = base + off_q;
  assign idx  = idx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      off_q <= '0;
      idx_q <= '0;
    end else if (load) begin
      off_q <= '0;
      idx_q <= '0;
    end else if (adv) begin
      if (last) begin
        off_q <= '0;
        idx_q <= '0;
      end else begin
        off_q <= off_q + step;
        idx_q <= idx_q + CW'(1);
      end
    end
  end

endmodule

// File: rtl/vls_pacer.sv
module vls_pacer #(
  parameter int PW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fire,
  input  logic [PW-1:0] prec,
  output logic          open
);
  import vls_pkg::*;

  localparam int GW = PW + 1;

  logic [GW-1:0] gap_q;

  assign open = (gap_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q <= '0;
    end else if (fire) begin
      gap_q <= GW'(pace_cycles(int'(prec)));
    end else if (!open) begin
      gap_q <= gap_q - GW'(1);
    end
  end

endmodule

// File: rtl/vec_loop_seq.sv
module vec_loop_seq #(
  parameter int AW  = 6,
  parameter int CW  = 6,
  parameter int PW  = 2,
  parameter int OPW = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_we,
  input  logic           cfg_bank,
  input  logic [AW-1:0]  cfg_in_start,
  input  logic [AW-1:0]  cfg_in_step,
  input  logic [CW-1:0]  cfg_in_size,
  input  logic [AW-1:0]  cfg_out_start,
  input  logic [AW-1:0]  cfg_out_step,
  input  logic [CW-1:0]  cfg_out_size,
  input  logic [AW-1:0]  cfg_dst,
  input  logic [PW-1:0]  cfg_prec,
  input  logic [OPW-1:0] cfg_op1,
  input  logic [OPW-1:0] cfg_op2,
  input  logic           cfg_bcast,
  input  logic           cfg_accum,
  output logic           next_bank,
  output logic           busy,
  output logic           done,
  output logic           step_valid,
  input  logic           step_ready,
  output logic [AW-1:0]  step_a_addr,
  output logic [AW-1:0]  step_b_addr,
  output logic [AW-1:0]  step_d_addr,
  output logic [OPW-1:0] step_op1,
  output logic [OPW-1:0] step_op2,
  output logic [PW-1:0]  step_prec,
  output logic           step_merge,
  output logic           step_first,
  output logic           step_last
);

  typedef struct packed {
    logic [AW-1:0]  in_start;
    logic [AW-1:0]  in_step;
    logic [CW-1:0]  in_size;
    logic [AW-1:0]  out_start;
    logic [AW-1:0]  out_step;
    logic [CW-1:0]  out_size;
    logic [AW-1:0]  dst;
    logic [PW-1:0]  prec;
    logic [OPW-1:0] op1;
    logic [OPW-1:0] op2;
    logic           bcast;
    logic           accum;
  } op_cfg_t;

  localparam int FW = $bits(op_cfg_t);

  op_cfg_t       wcfg;
  op_cfg_t       acfg;
  logic [FW-1:0] acfg_bits;
  logic          act_bank;
  logic          pend_valid;
  logic          take;
  logic          hs;
  logic          op_end;
  logic          busy_q;
  logic          done_q;
  logic          pace_open;

  logic [AW-1:0] in_addr,  out_addr;
  logic [CW-1:0] in_idx,   out_idx;
  logic          in_last,  out_last;
  logic [AW-1:0] d_off;

  assign wcfg = '{in_start: cfg_in_start, in_step: cfg_in_step, in_size: cfg_in_size,
                  out_start: cfg_out_start, out_step: cfg_out_step, out_size: cfg_out_size,
                  dst: cfg_dst, prec: cfg_prec, op1: cfg_op1, op2: cfg_op2,
                  bcast: cfg_bcast, accum: cfg_accum};

  vls_cfg_store #(.FW(FW)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr        (cfg_we),
    .wr_bank   (cfg_bank),
    .wr_data   (wcfg),
    .take      (take),
    .act_bank  (act_bank),
    .pend_valid(pend_valid),
    .act_data  (acfg_bits)
  );

  assign acfg = op_cfg_t'(acfg_bits);

  assign hs     = step_valid && step_ready;
  assign op_end = hs && in_last && out_last;
  // swap when idle, or exactly at the final handshake of the running op
  assign take   = pend_valid && (!busy_q || op_end);

  vls_loop_ctr #(.AW(AW), .CW(CW)) u_inner (
    .clk  (clk),
    .rst_n(rst_n),
    .load (take),
    .adv  (hs),
    .base (acfg.in_start),
    .step (acfg.in_step),
    .size (acfg.in_size),
    .addr (in_addr),
    .idx  (in_idx),
    .last (in_last)
  );

  vls_loop_ctr #(.AW(AW), .CW(CW)) u_outer (
    .clk  (clk),
    .rst_n(rst_n),
    .load (take),
    .adv  (hs && in_last),
    .base (acfg.out_start),
    .step (acfg.out_step),
    .size (acfg.out_size),
    .addr (out_addr),
    .idx  (out_idx),
    .last (out_last)
  );

  vls_pacer #(.PW(PW)) u_pace (
    .clk  (clk),
    .rst_n(rst_n),
    .fire (hs),
    .prec (acfg.prec),
    .open (pace_open)
  );

  // destination offset from the outer count, sized for either width order
  generate
    if (CW >= AW) begin : g_doff_trunc
      assign d_off = out_idx[AW-1:0];
    end else begin : g_doff_ext
      assign d_off = {{(AW-CW){1'b0}}, out_idx};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= op_end;
      if (take)        busy_q <= 1'b1;
      else if (op_end) busy_q <= 1'b0;
    end
  end

  assign step_valid  = busy_q && pace_open;
  assign step_a_addr = out_addr + in_addr;
  assign step_b_addr = acfg.bcast ? out_addr : in_addr;
  assign step_d_addr = acfg.dst + d_off;
  assign step_op1    = acfg.op1;
  assign step_op2    = acfg.op2;
  assign step_prec   = acfg.prec;
  assign step_merge  = acfg.accum;
  assign step_first  = (in_idx == '0);
  assign step_last   = in_last && out_last;

  assign busy      = busy_q;
  assign done      = done_q;
  assign next_bank = ~act_bank;

endmodule

// File: rtl/vec_loop_seq_chk.sv
module vec_loop_seq_chk #(
  parameter int AW = 6,
  parameter int PW = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          done,
  input logic          step_valid,
  input logic          step_ready,
  input logic [AW-1:0] step_a_addr,
  input logic [AW-1:0] step_b_addr,
  input logic [AW-1:0] step_d_addr,
  input logic [PW-1:0] step_prec,
  input logic          step_last
);
  localparam int CNTW = PW + 3;

  logic [CNTW-1:0] since_hs;
  logic [PW-1:0]   prec_at_hs;
  logic            hs;

  assign hs = step_valid && step_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_hs   <= '1;
      prec_at_hs <= '0;
    end else if (hs) begin
      since_hs   <= '0;
      prec_at_hs <= step_prec;
    end else if (since_hs != '1) begin
      since_hs <= since_hs + CNTW'(1);
    end
  end

  p_idle_silent_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !step_valid);

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    step_valid && !step_ready |=> step_valid && $stable(step_a_addr)
      && $stable(step_b_addr) && $stable(step_d_addr) && $stable(step_last));

  p_done_follows_r9: assert property (@(posedge clk) disable iff (!rst_n)
    hs && step_last |=> done);

  p_done_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(hs && step_last));

  p_pace_r7: assert property (@(posedge clk) disable iff (!rst_n)
    step_valid |-> (since_hs >= CNTW'(2 * prec_at_hs)));

endmodule

bind vec_loop_seq vec_loop_seq_chk #(.AW(AW), .PW(PW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .busy       (busy),
  .done       (done),
  .step_valid (step_valid),
  .step_ready (step_ready),
  .step_a_addr(step_a_addr),
  .step_b_addr(step_b_addr),
  .step_d_addr(step_d_addr),
  .step_prec  (step_prec),
  .step_last  (step_last)
);

// File: tb/vec_loop_seq_test.sv
`timescale 1ns/1ps
module vec_loop_seq_test;
  localparam int AW = 6, CW = 6, PW = 2, OPW = 3;
  localparam int DEPTH = 64;

  typedef struct {
    int is, it, isz, os, ot, osz, dst, prec, op1, op2, bc, ac;
  } cfg_t;

  logic clk = 0, rst_n = 0;
  logic cfg_we = 0, cfg_bank = 0;
  logic [AW-1:0] cfg_in_start = 0, cfg_in_step = 0, cfg_out_start = 0, cfg_out_step = 0, cfg_dst = 0;
  logic [CW-1:0] cfg_in_size = 0, cfg_out_size = 0;
  logic [PW-1:0] cfg_prec = 0;
  logic [OPW-1:0] cfg_op1 = 0, cfg_op2 = 0;
  logic cfg_bcast = 0, cfg_accum = 0;
  logic next_bank, busy, done, step_valid, step_ready = 1;
  logic [AW-1:0] step_a_addr, step_b_addr, step_d_addr;
  logic [OPW-1:0] step_op1, step_op2;
  logic [PW-1:0] step_prec;
  logic step_merge, step_first, step_last;

  always #2.5 clk = ~clk;

  vec_loop_seq #(.AW(AW), .CW(CW), .PW(PW), .OPW(OPW)) uut (.*);

  int tests = 0, fails = 0;
  cfg_t exp_q[$];
  int nb = 0, pushed = 0, done_cnt = 0, cyc = 0, rdy_mode = 0;
  int e_i = 0, e_j = 0, e_steps = 0, last_hs = 0, last_prec = 0;
  bit idle_seen = 1, prev_last_hs = 0, pv = 0, pr = 0;
  logic [AW-1:0] pa, pb, pd;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // ready pattern driven away from the sampling edge
  initial forever begin
    @(posedge clk); #1;
    step_ready = (rdy_mode == 0) ? 1'b1 : ((cyc % 3) != 1);
  end

  always @(negedge clk) if (rst_n) begin
    cfg_t c;
    int ni, no, inner, outer, ea, eb, ed;
    bit elast;
    cyc++;
    chk(done == prev_last_hs, "R9 done timing", done, prev_last_hs);
    if (done) done_cnt++;
    if (pv && !pr)
      chk(step_valid && step_a_addr == pa && step_b_addr == pb && step_d_addr == pd,
          "R8 hold under back-pressure", step_a_addr, pa);
    if (!busy) begin
      idle_seen = 1;
      chk(!step_valid, "R2 idle without step", step_valid, 0);
    end
    if (step_valid && step_ready) begin
      if (exp_q.size() == 0) chk(0, "R2 unexpected step", 1, 0);
      else begin
        c = exp_q[0];
        ni = (c.isz == 0) ? 1 : c.isz;  // R5: zero count acts as one
        no = (c.osz == 0) ? 1 : c.osz;
        inner = c.is + e_i * c.it;
        outer = c.os + e_j * c.ot;
        ea = (inner % DEPTH + outer % DEPTH) % DEPTH;
        eb = c.bc ? outer % DEPTH : inner % DEPTH;
        ed = (c.dst + e_j) % DEPTH;
        elast = (e_i == ni - 1) && (e_j == no - 1);
        chk(step_a_addr == ea, (inner % DEPTH + outer % DEPTH >= DEPTH) ? "R11 A wrap" : "R3 A addr", step_a_addr, ea);
        chk(step_b_addr == eb, c.bc ? "R4 broadcast B" : "R3 B addr", step_b_addr, eb);
        chk(step_d_addr == ed, "R3 D addr", step_d_addr, ed);
        chk(step_op1 == c.op1 && step_op2 == c.op2 && step_prec == c.prec && step_merge == c.ac,
            "R6 operator fields", {step_op1, step_op2, step_merge}, {c.op1[2:0], c.op2[2:0], c.ac[0]});
        chk(step_first == (e_i == 0) && step_last == elast, "R6 first/last",
            {step_first, step_last}, {(e_i == 0), elast});
        if (!idle_seen) begin
          if (rdy_mode == 0)
            chk(cyc - last_hs == 2 * last_prec + 1, (e_i == 0 && e_j == 0) ? "R10 back-to-back" : "R7 pace",
                cyc - last_hs, 2 * last_prec + 1);
          else
            chk(cyc - last_hs >= 2 * last_prec + 1, "R7 min pace", cyc - last_hs, 2 * last_prec + 1);
        end
        last_hs = cyc; last_prec = c.prec; idle_seen = 0; e_steps++;
        if (elast) begin
          chk(e_steps == ni * no, (c.isz == 0 || c.osz == 0) ? "R5 step count" : "R3 step count", e_steps, ni * no);
          void'(exp_q.pop_front());
          e_i = 0; e_j = 0; e_steps = 0;
        end else if (e_i == ni - 1) begin
          e_i = 0; e_j++;
        end else e_i++;
      end
    end
    prev_last_hs = step_valid && step_ready && step_last;
    pv = step_valid; pr = step_ready; pa = step_a_addr; pb = step_b_addr; pd = step_d_addr;
  end

  task automatic write_cfg(input int bank, input cfg_t c);
    @(posedge clk); #1;
    cfg_bank = bank[0];
    cfg_in_start = AW'(c.is); cfg_in_step = AW'(c.it); cfg_in_size = CW'(c.isz);
    cfg_out_start = AW'(c.os); cfg_out_step = AW'(c.ot); cfg_out_size = CW'(c.osz);
    cfg_dst = AW'(c.dst); cfg_prec = PW'(c.prec); cfg_op1 = OPW'(c.op1); cfg_op2 = OPW'(c.op2);
    cfg_bcast = c.bc[0]; cfg_accum = c.ac[0];
    cfg_we = 1;
    @(posedge clk); #1;
    cfg_we = 0;
  endtask

  task automatic queue_op(input cfg_t c);
    write_cfg(nb, c);
    exp_q.push_back(c);
    nb ^= 1; pushed++;
  endtask

  task automatic wait_idle();
    wait (exp_q.size() == 0);
    repeat (4) @(posedge clk);
  endtask

  function automatic cfg_t mk(input int p, input int m, input int s);
    cfg_t c;
    int isz_t[4] = '{1, 3, 0, 5};
    int osz_t[4] = '{1, 2, 3, 0};
    c.is = (58 + 3 * s) % DEPTH; c.it = 1 + s + p;
    c.isz = isz_t[s];
    c.os = (5 * m + 20 * s) % DEPTH; c.ot = 8 + 17 * s;
    c.osz = osz_t[s];
    c.dst = 62 - s; c.prec = p;
    c.op1 = (p + s) % 8; c.op2 = (m + s + 3) % 8;
    c.bc = m % 2; c.ac = m / 2;
    return c;
  endfunction

  initial begin
    fork
      begin
        cfg_t a, b;
        repeat (3) @(posedge clk); #1;
        // R1: reset state
        chk(busy == 0 && done == 0 && step_valid == 0, "R1 reset outputs", {busy, done, step_valid}, 0);
        chk(next_bank == 0, "R1 next bank", next_bank, 0);
        rst_n = 1;
        // R2: write to bank in use (bank 1 after reset) is ignored
        a = mk(0, 0, 1);
        write_cfg(1, a);
        repeat (10) @(posedge clk); #1;
        chk(busy == 0, "R2 write to active bank ignored", busy, 0);
        // sweep precision x broadcast/accumulate x loop shape
        for (int p = 0; p < 4; p++)
          for (int m = 0; m < 4; m++)
            for (int s = 0; s < 4; s++) begin
              rdy_mode = (p + m + s) % 2;
              queue_op(mk(p, m, s));
              wait_idle();
            end
        // R10: two queued operations, ready held high
        rdy_mode = 0;
        a = mk(1, 1, 1); b = mk(2, 2, 3);
        queue_op(a);
        queue_op(b);
        wait_idle();
        chk(busy == 0, "R10 idle after queue drains", busy, 0);
        // R2: writing the executing bank mid-run has no effect
        a = mk(0, 3, 1);
        queue_op(a);
        repeat (2) @(posedge clk);
        b = mk(3, 0, 3);
        write_cfg(nb ^ 1, b);
        wait_idle();
        repeat (10) @(posedge clk); #1;
        chk(busy == 0, "R2 mid-run write ignored", busy, 0);
        chk(done_cnt == pushed, "R9 done pulse count", done_cnt, pushed);
      end
      begin
        repeat (150000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog: run did not finish actual=0 expected=1");
      end
    join_any
    disable fork;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule